// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Driver

This block drives two positions of a four-position, common-select seven-segment display from a pair of BCD digits. The two positions take turns, so only one is lit at any moment. A free-running counter on the master clock sets the pace. One chosen counter bit decides which digit is shown. While that bit is 0 the tens digit goes through a 2-to-1 selector into a BCD-to-segment decoder and the tens position is enabled. While it is 1 the units digit goes through and the units position is enabled. When the switching is fast enough, both digits look steady to the eye.

The other two display positions are never used and their enables are held inactive. The segment lines are active high. The position enables are active low. BCD codes 10 through 15 blank the digit. The counter bit that acts as the select is a parameter, so a bench can shorten the refresh period a great deal.

Top module: `dual_digit_scan`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the refresh counter clears. Until the next time the select bit is reached, the tens position is the active one and `disp_en_n` reads 4'b1110.
- R2: With `rst` low, the active position swaps every 2**SEL_BIT rising clock edges. The tens position is active while (edges since reset / 2**SEL_BIT) is even, and the units position while it is odd.
- R3: While the tens position is active, `seg` shows the decoded `tens_bcd`. While the units position is active, `seg` shows the decoded `units_bcd`. A change on either input reaches `seg` in the same cycle, with no clock edge needed.
- R4: The `seg` bits are A=bit0, B=bit1, C=bit2, D=bit3, E=bit4, F=bit5 and G=bit6, and a segment is lit when its bit is 1. The codes 0 to 9 light these segments: 0: ABCDEF, 1: BC, 2: ABDEG, 3: ABCDG, 4: BCFG, 5: ACDFG, 6: ACDEFG, 7: ABC, 8: all seven, 9: ABCDFG.
- R5: A selected code from 10 to 15 drives `seg` to all zeros.
- R6: `disp_en_n[3:2]` is 2'b11 at all times.
- R7: Exactly one of `disp_en_n[1:0]` is 0. Bit 0 enables the tens position and bit 1 enables the units position.
- R8: Asserting `rst` at any point in the refresh cycle makes the tens position active again. Counting then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| tens_bcd | input | 4 | BCD tens digit |
| units_bcd | input | 4 | BCD units digit |
| seg | output | 7 | Segments A..G on bits 0..6, active high |
| disp_en_n | output | 4 | Position enables, active low; bits 3:2 held high |

## Verification
The bench builds the block with SEL_BIT set to 2, so each position stays active for four cycles and a full refresh period lasts eight. With that short period, every one of the 256 tens/units code pairs can be held through a full period. Each code, including the blanking codes, is therefore seen in both positions, and the swap edges are checked on every cycle. Because the period is short, a reset placed in the middle of the units phase can also be followed all the way back through its next swap.

// File: rtl/dd_scan_pkg.sv
package dd_scan_pkg;

    typedef logic [3:0] bcd_t;
    typedef logic [6:0] seg_t;

    typedef enum logic {
        POS_TENS  = 1'b0,
        POS_UNITS = 1'b1
    } pos_e;

    localparam int   NUM_POS   = 4;
    localparam int   LIVE_POS  = 2;
    localparam seg_t SEG_BLANK = 7'h00;

    // Segment vector: bit0=A ... bit6=G, 1 = lit.
    function automatic seg_t bcd_to_seg(input bcd_t code);
        seg_t s;
        unique case (code)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = SEG_BLANK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dd_refresh_div.sv
module dd_refresh_div
    import dd_scan_pkg::*;
#(
    parameter int SEL_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    output pos_e pos
);
    localparam int CNT_W = SEL_BIT + 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + CNT_W'(1);
    end

    assign pos = pos_e'(cnt[SEL_BIT]);

    // R2: counter advances by one on every unreset edge
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt == $past(cnt) + CNT_W'(1));

    // R2: the position only swaps when the low bits have just wrapped
    p_swap_on_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(pos) |-> cnt[SEL_BIT-1:0] == '0);

endmodule

// File: rtl/dd_digit_mux.sv
module dd_digit_mux
    import dd_scan_pkg::*;
(
    input  bcd_t tens,
    input  bcd_t units,
    input  pos_e pos,
    output bcd_t digit
);
    always_comb begin
        unique case (pos)
            POS_TENS:  digit = tens;
            POS_UNITS: digit = units;
            default:   digit = tens;
        endcase
    end
endmodule

// File: rtl/dd_seg_decode.sv
module dd_seg_decode
    import dd_scan_pkg::*;
(
    input  bcd_t digit,
    output seg_t seg
);
    assign seg = bcd_to_seg(digit);
endmodule

// File: rtl/dual_digit_scan.sv
module dual_digit_scan
    import dd_scan_pkg::*;
#(
    parameter int SEL_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] tens_bcd,
    input  logic [3:0] units_bcd,
    output logic [6:0] seg,
    output logic [3:0] disp_en_n
);
    pos_e pos;
    bcd_t digit;
    seg_t seg_w;

    dd_refresh_div #(.SEL_BIT(SEL_BIT)) u_div (
        .clk (clk),
        .rst (rst),
        .pos (pos)
    );

    dd_digit_mux u_mux (
        .tens  (tens_bcd),
        .units (units_bcd),
        .pos   (pos),
        .digit (digit)
    );

    dd_seg_decode u_dec (
        .digit (digit),
        .seg   (seg_w)
    );

    assign seg = seg_w;

    for (genvar gi = 0; gi < NUM_POS; gi++) begin : g_en
        if (gi < LIVE_POS) begin : g_live
            assign disp_en_n[gi] = (int'(pos) != gi);
        end else begin : g_dark
            assign disp_en_n[gi] = 1'b1;
        end
    end

    // R7: exactly one live position enabled
    p_one_active_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(disp_en_n[LIVE_POS-1:0]) == LIVE_POS - 1);

    // R3: enabled tens position carries the tens code
    p_tens_routed_r3: assert property (@(posedge clk) disable iff (rst)
        !disp_en_n[0] |-> digit == tens_bcd);

    // R3: enabled units position carries the units code
    p_units_routed_r3: assert property (@(posedge clk) disable iff (rst)
        !disp_en_n[1] |-> digit == units_bcd);

    // R5: out-of-range code leaves every segment dark
    p_blank_r5: assert property (@(posedge clk) disable iff (rst)
        digit > 4'd9 |-> seg == 7'h00);

    // R4: a valid code always lights something
    p_lit_r4: assert property (@(posedge clk) disable iff (rst)
        digit <= 4'd9 |-> seg != 7'h00);

endmodule

// File: tb/test_dual_digit_scan.sv
`timescale 1ns/1ps
module test_dual_digit_scan;
    localparam int SB     = 2;
    localparam int HALF   = 1 << SB;
    localparam int PERIOD = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tens_bcd = '0;
    logic [3:0] units_bcd = '0;
    logic [6:0] seg;
    logic [3:0] disp_en_n;

    int checks = 0;
    int fails  = 0;

    dual_digit_scan #(.SEL_BIT(SB)) i_dual_digit_scan (
        .clk       (clk),
        .rst       (rst),
        .tens_bcd  (tens_bcd),
        .units_bcd (units_bcd),
        .seg       (seg),
        .disp_en_n (disp_en_n)
    );

    always #10 clk = ~clk;

    // Segment pattern built from lit segment letters (A=bit0 .. G=bit6)
    function automatic logic [6:0] ref_seg(input logic [3:0] c);
        string lit;
        logic [6:0] v = '0;
        case (c)
            4'd0: lit = "ABCDEF";
            4'd1: lit = "BC";
            4'd2: lit = "ABDEG";
            4'd3: lit = "ABCDG";
            4'd4: lit = "BCFG";
            4'd5: lit = "ACDFG";
            4'd6: lit = "ACDEFG";
            4'd7: lit = "ABC";
            4'd8: lit = "ABCDEFG";
            4'd9: lit = "ABCDFG";
            default: lit = "";
        endcase
        for (int k = 0; k < lit.len(); k++) v[lit[k] - "A"] = 1'b1;
        return v;
    endfunction

    task automatic check7(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // edges = rising edges since reset released
    task automatic check_state(input int edges, input string tag);
        logic units_on;
        logic [3:0] shown;
        units_on = ((edges / HALF) % 2) == 1;
        shown    = units_on ? units_bcd : tens_bcd;
        check4({tag, " R2 R7 enables"}, disp_en_n, units_on ? 4'b1101 : 4'b1110);
        check4({tag, " R6 dark positions"}, {disp_en_n[3:2], 2'b00}, 4'b1100);
        check7({tag, (shown > 9) ? " R5 blank" : " R3 R4 segments"}, seg, ref_seg(shown));
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check4("R1 reset enables", disp_en_n, 4'b1110);
        check7("R1 reset segments", seg, ref_seg(4'd0));

        // Sweep every code pair through a full refresh period
        for (int n = 0; n < 256 * PERIOD; n++) begin
            if (n % PERIOD == 0) begin
                tens_bcd  = 4'((n / PERIOD) >> 4);
                units_bcd = 4'((n / PERIOD) & 15);
            end
            #1;
            check_state(n, "sweep");
            @(negedge clk);
        end

        // R3: combinational follow within a phase (tens phase at edge count 0 mod 8)
        tens_bcd  = 4'd7;
        units_bcd = 4'd2;
        #1;
        check7("R3 tens follow", seg, ref_seg(4'd7));
        tens_bcd = 4'd3;
        #1;
        check7("R3 tens follow change", seg, ref_seg(4'd3));

        // R8: reset in the middle of the units phase
        repeat (HALF + 1) @(negedge clk);
        #1;
        check4("R8 pre-reset in units phase", disp_en_n, 4'b1101);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check4("R8 tens after reset", disp_en_n, 4'b1110);
        check7("R8 tens segments after reset", seg, ref_seg(4'd3));
        for (int n = 1; n <= PERIOD; n++) begin
            @(negedge clk);
            #1;
            check_state(n, "R8 restart");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule